// File: doc/BRIEF.md
# Conditional Data-Processing ALU

This block executes one data-processing operation per clock. It takes a first operand, a second operand that a barrel shifter has already prepared, the shifter's carry-out and the current N, Z, C and V flags. It first decides from a 4-bit condition code whether the operation may take effect. It then computes one of sixteen operations: logical, add and subtract forms, reverse-subtract forms, carry-propagating forms and four test/compare forms that only affect the flags.

The result, a destination-write enable and the next flag vector are registered, so they appear one clock after the inputs are presented. A register-file and flag-register stage placed downstream consumes them. When the condition fails, nothing is written and the flags pass through unchanged. When the set-flags input is low, the flags also pass through unchanged.

Top module: `dp_alu_exec`

## Requirements
- R1: While `rst` is high at a clock edge, `result_o`, `rd_we_o` and `nzcv_o` are all cleared to zero on that edge.
- R2: The condition code selects the test: 0 Z set; 1 Z clear; 2 C set; 3 C clear; 4 N set; 5 N clear; 6 V set; 7 V clear; 8 C set and Z clear; 9 C clear or Z set; 10 N equal V; 11 N differs from V; 12 Z clear and N equal V; 13 Z set or N differs from V; 14 always. Flags are packed as bit 3 N, bit 2 Z, bit 1 C, bit 0 V.
- R3: Condition code 15 never passes. `rd_we_o` is 0 and `nzcv_o` equals the incoming flags.
- R4: When the condition fails, `rd_we_o` is 0 and `nzcv_o` equals the incoming flags, whatever the opcode and set-flags value.
- R5: The logical opcodes are 0 AND, 1 XOR, 12 OR, 13 move (op2), 14 Rn AND NOT op2, and 15 NOT op2. When flags are set, C takes `shift_carry_i` and V keeps its incoming value.
- R6: The arithmetic opcodes are 2 Rn-op2, 3 op2-Rn, 4 Rn+op2, 5 Rn+op2+C, 6 Rn-op2+C-1, and 7 op2-Rn+C-1. When flags are set, C is the carry out of the adder, which for a subtraction means no borrow occurred, and V is signed overflow.
- R7: Opcodes 8, 9, 10 and 11 compute AND, XOR, subtract and add respectively. They never raise `rd_we_o`, but they update the flags as R5/R6 describe when the set-flags input is high.
- R8: With `set_flags_i` low, `nzcv_o` equals the incoming flags even when the operation executes.
- R9: Whenever the flags are updated, N equals the result's most significant bit and Z is 1 exactly when the result is zero.
- R10: `result_o` always carries the computed value of the opcode. Every output reflects the inputs sampled at the previous rising clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cond_i | input | 4 | Condition code |
| opcode_i | input | 4 | Operation select |
| set_flags_i | input | 1 | Allow flag update |
| rn_i | input | WIDTH | First operand |
| op2_i | input | WIDTH | Pre-shifted second operand |
| shift_carry_i | input | 1 | Carry-out of the operand shifter |
| nzcv_i | input | 4 | Current flags {N,Z,C,V} |
| result_o | output | WIDTH | Registered operation result |
| rd_we_o | output | 1 | Registered destination write enable |
| nzcv_o | output | 4 | Registered next flags |

## Verification
Properties check several rules on every cycle: code 15 suppresses the write and holds the flags, the four test/compare opcodes never write, a low set-flags input leaves the flags untouched, N and Z follow the registered result whenever flags are updated, and logical operations keep V. The arithmetic values and the carry and overflow semantics of each subtract and carry form can only be shown by the bench's operand sweeps, which use boundary values such as 0, 1, the largest positive value and the most negative value. The same holds for the full fifteen-entry condition table swept against all sixteen flag combinations.

// File: rtl/dpalu_pkg.sv
package dpalu_pkg;
  typedef enum logic [3:0] {
    OP_AND   = 4'd0,  OP_XOR   = 4'd1,  OP_SUB   = 4'd2,  OP_RSUB  = 4'd3,
    OP_ADD   = 4'd4,  OP_ADDC  = 4'd5,  OP_SUBC  = 4'd6,  OP_RSUBC = 4'd7,
    OP_TEST  = 4'd8,  OP_TEQV  = 4'd9,  OP_CMPS  = 4'd10, OP_CMPA  = 4'd11,
    OP_OR    = 4'd12, OP_MOVE  = 4'd13, OP_CLR   = 4'd14, OP_NOT   = 4'd15
  } dp_op_e;

  localparam int FL_N = 3;
  localparam int FL_Z = 2;
  localparam int FL_C = 1;
  localparam int FL_V = 0;

  function automatic logic op_flags_only(input logic [3:0] op);
    return op[3:2] == 2'b10;
  endfunction

  function automatic logic op_uses_adder(input logic [3:0] op);
    return (op[3:2] == 2'b01) || (op[3:1] == 3'b001) || (op[3:1] == 3'b101);
  endfunction
endpackage

// File: rtl/dp_cond_eval.sv
module dp_cond_eval
  import dpalu_pkg::*;
(
  input  logic [3:0] cond,
  input  logic [3:0] nzcv,
  output logic       pass
);
  logic n, z, c, v;
  assign n = nzcv[FL_N];
  assign z = nzcv[FL_Z];
  assign c = nzcv[FL_C];
  assign v = nzcv[FL_V];

  always_comb begin
    unique case (cond)
      4'd0:    pass = z;
      4'd1:    pass = !z;
      4'd2:    pass = c;
      4'd3:    pass = !c;
      4'd4:    pass = n;
      4'd5:    pass = !n;
      4'd6:    pass = v;
      4'd7:    pass = !v;
      4'd8:    pass = c && !z;
      4'd9:    pass = !c || z;
      4'd10:   pass = (n == v);
      4'd11:   pass = (n != v);
      4'd12:   pass = !z && (n == v);
      4'd13:   pass = z || (n != v);
      4'd14:   pass = 1'b1;
      default: pass = 1'b0;
    endcase
  end
endmodule

// File: rtl/dp_logic_unit.sv
module dp_logic_unit
  import dpalu_pkg::*;
#(
  parameter int WIDTH = 32
) (
  input  logic [3:0]       op,
  input  logic [WIDTH-1:0] a,
  input  logic [WIDTH-1:0] b,
  output logic [WIDTH-1:0] y
);
  always_comb begin
    unique case (dp_op_e'(op))
      OP_AND, OP_TEST: y = a & b;
      OP_XOR, OP_TEQV: y = a ^ b;
      OP_OR:           y = a | b;
      OP_MOVE:         y = b;
      OP_CLR:          y = a & ~b;
      OP_NOT:          y = ~b;
      default:         y = '0;
    endcase
  end
endmodule

// File: rtl/dp_addsub_unit.sv
module dp_addsub_unit
  import dpalu_pkg::*;
#(
  parameter int WIDTH = 32
) (
  input  logic [3:0]       op,
  input  logic [WIDTH-1:0] a,
  input  logic [WIDTH-1:0] b,
  input  logic             cin,
  output logic [WIDTH-1:0] sum,
  output logic             cout,
  output logic             ovf
);
  localparam int MSB = WIDTH - 1;

  logic [WIDTH-1:0] x, y, yy;
  logic             inv, ci;
  logic [WIDTH:0]   full;

  always_comb begin
    x   = a;
    y   = b;
    inv = 1'b0;
    ci  = 1'b0;
    unique case (dp_op_e'(op))
      OP_SUB, OP_CMPS: begin inv = 1'b1; ci = 1'b1; end
      OP_RSUB:         begin x = b; y = a; inv = 1'b1; ci = 1'b1; end
      OP_ADDC:         ci = cin;
      OP_SUBC:         begin inv = 1'b1; ci = cin; end
      OP_RSUBC:        begin x = b; y = a; inv = 1'b1; ci = cin; end
      default:         ;
    endcase
  end

  assign yy   = inv ? ~y : y;
  assign full = {1'b0, x} + {1'b0, yy} + {{WIDTH{1'b0}}, ci};
  assign sum  = full[MSB:0];
  assign cout = full[WIDTH];
  assign ovf  = (x[MSB] == yy[MSB]) && (sum[MSB] != x[MSB]);
endmodule

// File: rtl/dp_alu_exec.sv
module dp_alu_exec
  import dpalu_pkg::*;
#(
  parameter int WIDTH = 32
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [3:0]       cond_i,
  input  logic [3:0]       opcode_i,
  input  logic             set_flags_i,
  input  logic [WIDTH-1:0] rn_i,
  input  logic [WIDTH-1:0] op2_i,
  input  logic             shift_carry_i,
  input  logic [3:0]       nzcv_i,
  output logic [WIDTH-1:0] result_o,
  output logic             rd_we_o,
  output logic [3:0]       nzcv_o
);
  localparam int MSB = WIDTH - 1;

  logic             pass;
  logic [WIDTH-1:0] logic_y, arith_y, res_d;
  logic             arith_c, arith_v, use_adder, we_d;
  logic [3:0]       flags_d;

  dp_cond_eval u_cond (
    .cond (cond_i),
    .nzcv (nzcv_i),
    .pass (pass)
  );

  dp_logic_unit #(.WIDTH(WIDTH)) u_logic (
    .op (opcode_i),
    .a  (rn_i),
    .b  (op2_i),
    .y  (logic_y)
  );

  dp_addsub_unit #(.WIDTH(WIDTH)) u_arith (
    .op   (opcode_i),
    .a    (rn_i),
    .b    (op2_i),
    .cin  (nzcv_i[FL_C]),
    .sum  (arith_y),
    .cout (arith_c),
    .ovf  (arith_v)
  );

  assign use_adder = op_uses_adder(opcode_i);
  assign res_d     = use_adder ? arith_y : logic_y;
  assign we_d      = pass && !op_flags_only(opcode_i);

  always_comb begin
    flags_d = nzcv_i;
    if (pass && set_flags_i) begin
      flags_d[FL_N] = res_d[MSB];
      flags_d[FL_Z] = (res_d == '0);
      flags_d[FL_C] = use_adder ? arith_c : shift_carry_i;
      flags_d[FL_V] = use_adder ? arith_v : nzcv_i[FL_V];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      result_o <= '0;
      rd_we_o  <= 1'b0;
      nzcv_o   <= 4'b0;
    end else begin
      result_o <= res_d;
      rd_we_o  <= we_d;
      nzcv_o   <= flags_d;
    end
  end

  AST_NEVER_CODE_IDLE: assert property (@(posedge clk) disable iff (rst)
    (cond_i == 4'hF) |=> (!rd_we_o && nzcv_o == $past(nzcv_i))); // R3

  AST_FAIL_HOLDS_STATE: assert property (@(posedge clk) disable iff (rst)
    !pass |=> (!rd_we_o && nzcv_o == $past(nzcv_i))); // R4

  AST_TEST_NO_WRITE: assert property (@(posedge clk) disable iff (rst)
    (opcode_i[3:2] == 2'b10) |=> !rd_we_o); // R7

  AST_SBIT_CLEAR_HOLD: assert property (@(posedge clk) disable iff (rst)
    !set_flags_i |=> (nzcv_o == $past(nzcv_i))); // R8

  AST_NZ_FOLLOW_RESULT: assert property (@(posedge clk) disable iff (rst)
    (pass && set_flags_i) |=> (nzcv_o[FL_N] == result_o[MSB] &&
                               nzcv_o[FL_Z] == (result_o == '0))); // R9

  AST_LOGIC_KEEPS_V: assert property (@(posedge clk) disable iff (rst)
    (pass && set_flags_i && !use_adder) |=>
      (nzcv_o[FL_V] == $past(nzcv_i[FL_V]) &&
       nzcv_o[FL_C] == $past(shift_carry_i))); // R5
endmodule

// File: tb/tb_dp_alu_exec.sv
module tb_dp_alu_exec;
  localparam int CLK_P = 10;
  localparam int W = 32;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic [3:0]   cond_i = 4'hE, opcode_i = 4'd0, nzcv_i = 4'd0;
  logic         set_flags_i = 1'b0, shift_carry_i = 1'b0;
  logic [W-1:0] rn_i = '0, op2_i = '0;
  logic [W-1:0] result_o;
  logic         rd_we_o;
  logic [3:0]   nzcv_o;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #(CLK_P/2) clk = ~clk;

  dp_alu_exec #(.WIDTH(W)) dut (
    .clk(clk), .rst(rst), .cond_i(cond_i), .opcode_i(opcode_i),
    .set_flags_i(set_flags_i), .rn_i(rn_i), .op2_i(op2_i),
    .shift_carry_i(shift_carry_i), .nzcv_i(nzcv_i),
    .result_o(result_o), .rd_we_o(rd_we_o), .nzcv_o(nzcv_o)
  );

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic bit cond_model(input logic [3:0] c, input logic [3:0] f);
    bit n = f[3], z = f[2], cy = f[1], v = f[0];
    bit base;
    case (c[3:1])
      3'd0: base = z;
      3'd1: base = cy;
      3'd2: base = n;
      3'd3: base = v;
      3'd4: base = cy & ~z;
      3'd5: base = (n == v);
      3'd6: base = ~z & (n == v);
      default: base = 1'b1;
    endcase
    if (c == 4'hF) return 1'b0;
    if (c == 4'hE) return 1'b1;
    return c[0] ? ~base : base;
  endfunction

  // Expected outputs from the requirement text
  task automatic model(input logic [3:0] c, input logic [3:0] op, input bit s,
                       input logic [W-1:0] a, input logic [W-1:0] b,
                       input bit shc, input logic [3:0] f,
                       output logic [W-1:0] r, output bit we, output logic [3:0] nf);
    longint ua = longint'(a), ub = longint'(b);
    longint sa = longint'($signed(a)), sb = longint'($signed(b));
    longint cf = longint'(f[1]);
    longint u = 0, sv = 0;
    bit arith = 1'b1, sub_form = 1'b0;
    case (op)
      4'd2, 4'd10: begin u = ua - ub;          sv = sa - sb;          sub_form = 1; end
      4'd3:        begin u = ub - ua;          sv = sb - sa;          sub_form = 1; end
      4'd4, 4'd11: begin u = ua + ub;          sv = sa + sb;          end
      4'd5:        begin u = ua + ub + cf;     sv = sa + sb + cf;     end
      4'd6:        begin u = ua - ub + cf - 1; sv = sa - sb + cf - 1; sub_form = 1; end
      4'd7:        begin u = ub - ua + cf - 1; sv = sb - sa + cf - 1; sub_form = 1; end
      default: arith = 1'b0;
    endcase
    case (op)
      4'd0, 4'd8:  r = a & b;
      4'd1, 4'd9:  r = a ^ b;
      4'd12:       r = a | b;
      4'd13:       r = b;
      4'd14:       r = a & ~b;
      4'd15:       r = ~b;
      default:     r = u[W-1:0];
    endcase
    we = cond_model(c, f) && !(op >= 4'd8 && op <= 4'd11);
    nf = f;
    if (cond_model(c, f) && s) begin
      nf[3] = r[W-1];
      nf[2] = (r == '0);
      if (arith) begin
        nf[1] = sub_form ? (u >= 0) : (u >= 64'sh1_0000_0000);
        nf[0] = (sv > 64'sh7FFF_FFFF) || (sv < -64'sh8000_0000);
      end else begin
        nf[1] = shc;
      end
    end
  endtask

  task automatic run(input string req, input logic [3:0] c, input logic [3:0] op,
                     input bit s, input logic [W-1:0] a, input logic [W-1:0] b,
                     input bit shc, input logic [3:0] f, input bit cmp_res);
    logic [W-1:0] er; bit ew; logic [3:0] ef;
    cond_i = c; opcode_i = op; set_flags_i = s; rn_i = a; op2_i = b;
    shift_carry_i = shc; nzcv_i = f;
    model(c, op, s, a, b, shc, f, er, ew, ef);
    @(posedge clk);
    #(CLK_P/4);
    if (cmp_res) chk({req, " result"}, 64'(result_o), 64'(er));
    chk({req, " write"}, 64'(rd_we_o), 64'(ew));
    chk({req, " flags"}, 64'(nzcv_o), 64'(ef));
  endtask

  logic [W-1:0] pats [8];

  initial begin
    #(CLK_P * 200000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    pats[0] = 32'h0000_0000; pats[1] = 32'h0000_0001; pats[2] = 32'h7FFF_FFFF;
    pats[3] = 32'h8000_0000; pats[4] = 32'hFFFF_FFFF; pats[5] = 32'h1234_5678;
    pats[6] = 32'hA5A5_A5A5; pats[7] = 32'h0000_0002;

    // R1: reset clears everything
    repeat (2) @(posedge clk);
    #(CLK_P/4);
    chk("R1 result", 64'(result_o), 64'd0);
    chk("R1 write", 64'(rd_we_o), 64'd0);
    chk("R1 flags", 64'(nzcv_o), 64'd0);
    rst = 1'b0;

    // R10: outputs stay until the next edge, then follow the inputs
    run("R10 warmup", 4'hE, 4'd13, 1'b0, '0, 32'h0000_0055, 1'b0, 4'h0, 1'b1);
    op2_i = 32'h0000_00AA;
    #1;
    chk("R10 hold before edge", 64'(result_o), 64'h55);
    @(posedge clk);
    #(CLK_P/4);
    chk("R10 after edge", 64'(result_o), 64'hAA);

    // R2 R3 R4: every condition code against every flag combination
    for (int c = 0; c < 16; c++) begin
      for (int f = 0; f < 16; f++) begin
        if (c == 15) run("R3", 4'(c), 4'd4, 1'b1, 32'h3, 32'h5, 1'b1, 4'(f), 1'b1);
        else if (!cond_model(4'(c), 4'(f)))
          run("R4", 4'(c), 4'd4, 1'b1, 32'h3, 32'h5, 1'b1, 4'(f), 1'b1);
        else run("R2", 4'(c), 4'd4, 1'b1, 32'h3, 32'h5, 1'b1, 4'(f), 1'b1);
      end
    end

    // R5 R6 R7 R9: all opcodes, boundary operand pairs, both carries
    for (int op = 0; op < 16; op++) begin
      for (int i = 0; i < 8; i++) begin
        for (int j = 0; j < 8; j++) begin
          for (int k = 0; k < 4; k++) begin
            string tag;
            if (op >= 8 && op <= 11) tag = "R7";
            else if (op >= 2 && op <= 7) tag = "R6 R9";
            else tag = "R5 R9";
            run(tag, 4'hE, 4'(op), 1'b1, pats[i], pats[j], k[0],
                {2'b00, k[1], ~k[0]}, 1'b1);
          end
        end
      end
    end

    // R8: executing with flag update disabled
    for (int op = 0; op < 16; op++) begin
      for (int f = 0; f < 16; f += 5)
        run("R8", 4'hE, 4'(op), 1'b0, pats[4], pats[1], 1'b1, 4'(f), 1'b1);
    end

    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule